// File: doc/BRIEF.md
# Interrupt Priority Arbiter with Programmable Group Split

This block picks, out of a set of pending interrupt request lines, the one that should be served next, and says whether that request is urgent enough to interrupt the request already in service. Each line owns a priority byte that software reaches through a small write/read register port. Only the upper nibble of each byte is stored. A smaller value means a more urgent request.

A 3-bit grouping control places a binary point inside every priority byte. Bits above the point form the group (pre-emption) level and bits below it form the subpriority. The winner among pending lines is the one with the lowest group level, then the lowest subpriority, then the lowest line index. Only the group level is compared against the active request when deciding pre-emption. Changing the grouping control changes how the stored bytes are read as levels. It does not alter the stored bytes.

The outputs are combinational functions of the stored state and the current pending and active inputs. A register write therefore shows up on the outputs in the cycle after the write edge.

Top module: `irq_prio_arb`

## Requirements
- R1: The grouping value g places the group field at bits [7:g+1] and the subpriority at bits [g:0]. For g=4 the group is bits [7:5], for g=5 it is [7:6], for g=6 it is [7], and for g=7 there is no group field: every line is at group level 0.
- R2: After reset the grouping value reads 0 and every priority byte reads 0x00.
- R3: A priority write keeps only data bits [7:4]. Bits [3:0] of every priority byte always read back as zero.
- R4: With a grouping value from 0 to 3, all four stored bits belong to the group field, so any difference in stored priority is a difference in group level.
- R5: `preempt` is high only when the winner's group level is strictly lower than the active line's group level. Equal group levels never pre-empt.
- R6: Writing the grouping value leaves every stored priority byte unchanged.
- R7: Among pending lines, the winner has the lowest group level. Among lines with equal group level, the winner has the lowest subpriority.
- R8: When pending lines have equal stored priority, the lowest-numbered line wins.
- R9: `preempt` is low whenever `act_valid` is low.
- R10: With no line pending, `win_valid` is 0 and `win_idx` is 0.
- R11: A priority or grouping write takes effect on the readback and arbitration outputs in the cycle after the write edge. `grp_value` shows the stored grouping value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| prio_wr_en | input | 1 | Write strobe for a priority byte |
| prio_addr | input | 3 | Line selected for write and readback |
| prio_wdata | input | 8 | Priority write data |
| prio_rdata | output | 8 | Stored priority of the selected line |
| grp_wr_en | input | 1 | Write strobe for the grouping value |
| grp_wdata | input | 3 | New grouping value |
| grp_value | output | 3 | Current grouping value |
| pend | input | 8 | Pending request per line |
| act_valid | input | 1 | A request is currently in service |
| act_idx | input | 3 | Line number of the request in service |
| win_valid | output | 1 | At least one line is pending |
| win_idx | output | 3 | Index of the winning line |
| preempt | output | 1 | Winner may pre-empt the active request |

## Verification
The assertions assume `prio_addr` and `act_idx` always name an existing line. They also assume `act_idx` carries meaning only while `act_valid` is high. The readback property assumes the address is held steady across a write so that the following cycle reads the same line. The bench drives every input on the falling clock edge, writes only to addresses inside the line count, and keeps the address fixed through each write-then-read pair. Any reads it makes before a write completes are treated as expected to return the old value.

// File: rtl/irq_prio_pkg.sv
package irq_prio_pkg;
  localparam int PRIO_W   = 8;
  localparam int GRP_W    = 3;
  localparam logic [PRIO_W-1:0] IMPL_MASK = 8'hF0;

  // Mask of the bits above the binary point for grouping value g
  function automatic logic [PRIO_W-1:0] grp_mask(input logic [GRP_W-1:0] g);
    logic [PRIO_W:0] m;
    m = {(PRIO_W+1){1'b1}} << (int'(g) + 1);
    return m[PRIO_W-1:0];
  endfunction

  // Group (pre-emption) portion of a priority byte
  function automatic logic [PRIO_W-1:0] grp_key(input logic [PRIO_W-1:0] p,
                                                input logic [GRP_W-1:0] g);
    return p & grp_mask(g);
  endfunction
endpackage

// File: rtl/irq_prio_regs.sv
module irq_prio_regs
  import irq_prio_pkg::*;
#(
  parameter int NUM_LINES = 8,
  localparam int IDX_W = $clog2(NUM_LINES)
) (
  input  logic                               clk,
  input  logic                               rst_n,
  input  logic                               prio_wr_en,
  input  logic [IDX_W-1:0]                   prio_addr,
  input  logic [PRIO_W-1:0]                  prio_wdata,
  output logic [PRIO_W-1:0]                  prio_rdata,
  input  logic                               grp_wr_en,
  input  logic [GRP_W-1:0]                   grp_wdata,
  output logic [GRP_W-1:0]                   grp_value,
  output logic [NUM_LINES-1:0][PRIO_W-1:0]   prio_all
);
  logic [NUM_LINES-1:0][PRIO_W-1:0] prio_q;
  logic [GRP_W-1:0]                 grp_q;

  generate
    for (genvar i = 0; i < NUM_LINES; i++) begin : g_line
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
          prio_q[i] <= '0;
        else if (prio_wr_en && prio_addr == IDX_W'(i))
          prio_q[i] <= prio_wdata & IMPL_MASK;
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         grp_q <= '0;
    else if (grp_wr_en) grp_q <= grp_wdata;
  end

  assign prio_rdata = prio_q[prio_addr];
  assign grp_value  = grp_q;
  assign prio_all   = prio_q;

  AST_WRITE_READBACK: assert property (@(posedge clk) disable iff (!rst_n)
    prio_wr_en |=> ($stable(prio_addr) -> prio_rdata == ($past(prio_wdata) & 8'hF0))); // R3
  AST_BYTES_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
    !prio_wr_en |=> $stable(prio_all)); // R6
  AST_GRP_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    !grp_wr_en |=> $stable(grp_value)); // R11
endmodule

// File: rtl/irq_prio_select.sv
module irq_prio_select
  import irq_prio_pkg::*;
#(
  parameter int NUM_LINES = 8,
  localparam int IDX_W = $clog2(NUM_LINES)
) (
  input  logic                             clk,
  input  logic                             rst_n,
  input  logic [NUM_LINES-1:0]             pend,
  input  logic [NUM_LINES-1:0][PRIO_W-1:0] prio_all,
  output logic                             win_valid,
  output logic [IDX_W-1:0]                 win_idx,
  output logic [PRIO_W-1:0]                win_prio
);
  // The byte already orders group bits above subpriority bits, so a plain
  // minimum of the byte ranks by group first, then subpriority.
  always_comb begin
    win_valid = 1'b0;
    win_idx   = '0;
    win_prio  = '1;
    for (int i = 0; i < NUM_LINES; i++) begin
      if (pend[i] && (!win_valid || prio_all[i] < win_prio)) begin
        win_valid = 1'b1;
        win_idx   = IDX_W'(i);
        win_prio  = prio_all[i];
      end
    end
  end

  AST_IDLE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (pend == '0) |-> (!win_valid && win_idx == '0)); // R10
  AST_WIN_IS_PENDING: assert property (@(posedge clk) disable iff (!rst_n)
    win_valid |-> pend[win_idx]); // R7
endmodule

// File: rtl/irq_prio_preempt.sv
module irq_prio_preempt
  import irq_prio_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [GRP_W-1:0]  grp_value,
  input  logic              win_valid,
  input  logic [PRIO_W-1:0] win_prio,
  input  logic              act_valid,
  input  logic [PRIO_W-1:0] act_prio,
  output logic              preempt
);
  logic [PRIO_W-1:0] win_grp, act_grp;

  assign win_grp = grp_key(win_prio, grp_value);
  assign act_grp = grp_key(act_prio, grp_value);
  assign preempt = act_valid && win_valid && (win_grp < act_grp);

  AST_PREEMPT_NEEDS_ACT: assert property (@(posedge clk) disable iff (!rst_n)
    preempt |-> (act_valid && win_valid)); // R9
  AST_PREEMPT_MORE_URGENT: assert property (@(posedge clk) disable iff (!rst_n)
    preempt |-> (win_prio < act_prio)); // R5
endmodule

// File: rtl/irq_prio_arb.sv
module irq_prio_arb
  import irq_prio_pkg::*;
#(
  parameter int NUM_LINES = 8,
  localparam int IDX_W = $clog2(NUM_LINES)
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  prio_wr_en,
  input  logic [IDX_W-1:0]      prio_addr,
  input  logic [7:0]            prio_wdata,
  output logic [7:0]            prio_rdata,
  input  logic                  grp_wr_en,
  input  logic [2:0]            grp_wdata,
  output logic [2:0]            grp_value,
  input  logic [NUM_LINES-1:0]  pend,
  input  logic                  act_valid,
  input  logic [IDX_W-1:0]      act_idx,
  output logic                  win_valid,
  output logic [IDX_W-1:0]      win_idx,
  output logic                  preempt
);
  logic [NUM_LINES-1:0][PRIO_W-1:0] prio_all;
  logic [PRIO_W-1:0]                win_prio;
  logic [PRIO_W-1:0]                act_prio;

  irq_prio_regs #(.NUM_LINES(NUM_LINES)) u_regs (
    .clk(clk), .rst_n(rst_n),
    .prio_wr_en(prio_wr_en), .prio_addr(prio_addr),
    .prio_wdata(prio_wdata), .prio_rdata(prio_rdata),
    .grp_wr_en(grp_wr_en), .grp_wdata(grp_wdata),
    .grp_value(grp_value), .prio_all(prio_all)
  );

  irq_prio_select #(.NUM_LINES(NUM_LINES)) u_sel (
    .clk(clk), .rst_n(rst_n), .pend(pend), .prio_all(prio_all),
    .win_valid(win_valid), .win_idx(win_idx), .win_prio(win_prio)
  );

  assign act_prio = prio_all[act_idx];

  irq_prio_preempt u_pre (
    .clk(clk), .rst_n(rst_n), .grp_value(grp_value),
    .win_valid(win_valid), .win_prio(win_prio),
    .act_valid(act_valid), .act_prio(act_prio), .preempt(preempt)
  );
endmodule

// File: tb/irq_prio_arb_tb.sv
module irq_prio_arb_tb_top;
  localparam int N = 8;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       prio_wr_en = 1'b0;
  logic [2:0] prio_addr = '0;
  logic [7:0] prio_wdata = '0;
  logic [7:0] prio_rdata;
  logic       grp_wr_en = 1'b0;
  logic [2:0] grp_wdata = '0;
  logic [2:0] grp_value;
  logic [N-1:0] pend = '0;
  logic       act_valid = 1'b0;
  logic [2:0] act_idx = '0;
  logic       win_valid;
  logic [2:0] win_idx;
  logic       preempt;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;
  logic [7:0] model [N];
  int cur_g = 0;

  always #5 clk = ~clk;

  irq_prio_arb dut_i (
    .clk(clk), .rst_n(rst_n), .prio_wr_en(prio_wr_en), .prio_addr(prio_addr),
    .prio_wdata(prio_wdata), .prio_rdata(prio_rdata), .grp_wr_en(grp_wr_en),
    .grp_wdata(grp_wdata), .grp_value(grp_value), .pend(pend),
    .act_valid(act_valid), .act_idx(act_idx), .win_valid(win_valid),
    .win_idx(win_idx), .preempt(preempt)
  );

  task automatic check(string req, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Group level: keep the top n stored bits, n = min(4, 7-g)
  function automatic int grp_level(logic [7:0] p, int g);
    int n = (7 - g) > 4 ? 4 : 7 - g;
    if (n == 0) return 0;
    return int'(p) >> (8 - n);
  endfunction

  task automatic wr_prio(int line, logic [7:0] v);
    @(negedge clk);
    prio_wr_en = 1'b1; prio_addr = 3'(line); prio_wdata = v;
    @(negedge clk);
    prio_wr_en = 1'b0;
    model[line] = v & 8'hF0;
  endtask

  task automatic wr_grp(int g);
    @(negedge clk);
    grp_wr_en = 1'b1; grp_wdata = 3'(g);
    @(negedge clk);
    grp_wr_en = 1'b0;
    cur_g = g;
  endtask

  task automatic drive(logic [N-1:0] p, logic av, int ai);
    @(negedge clk);
    pend = p; act_valid = av; act_idx = 3'(ai);
    #1;
  endtask

  task automatic expect_win(string req, logic [N-1:0] p, logic av, int ai);
    int ei = 0; bit ev = 0; int ep = 0;
    drive(p, av, ai);
    for (int i = 0; i < N; i++)
      if (p[i] && (!ev || model[i] < model[ei])) begin ev = 1; ei = i; end
    if (ev && av && grp_level(model[ei], cur_g) < grp_level(model[ai], cur_g)) ep = 1;
    check(req, int'(win_valid), int'(ev));
    check(req, int'(win_idx), ei);
    check(req, int'(preempt), ep);
  endtask

  task automatic t_reset();
    check("R2 grp", int'(grp_value), 0);
    for (int i = 0; i < N; i++) begin
      @(negedge clk); prio_addr = 3'(i); #1;
      check("R2 prio", int'(prio_rdata), 0);
    end
    expect_win("R10", '0, 1'b0, 0);
  endtask

  task automatic t_readback();
    @(negedge clk);
    prio_wr_en = 1'b1; prio_addr = 3'd5; prio_wdata = 8'h9B;
    #1 check("R11 old", int'(prio_rdata), 0);
    @(negedge clk); prio_wr_en = 1'b0; #1;
    check("R3 R11", int'(prio_rdata), 8'h90);
    model[5] = 8'h90;
    wr_prio(5, 8'h0F);
    @(negedge clk); prio_addr = 3'd5; #1;
    check("R3 low", int'(prio_rdata), 0);
  endtask

  task automatic t_select();
    wr_prio(0, 8'hC0); wr_prio(1, 8'h50); wr_prio(2, 8'h30);
    wr_prio(3, 8'h30); wr_prio(4, 8'hF0); wr_prio(6, 8'h50); wr_prio(7, 8'h10);
    expect_win("R7", 8'b0001_0011, 1'b0, 0);   // line 4 loses to 1
    expect_win("R8", 8'b0000_1100, 1'b0, 0);   // lines 2,3 tie
    expect_win("R8 single", 8'b1000_0000, 1'b0, 0);
    expect_win("R10", 8'b0000_0000, 1'b1, 1);
  endtask

  task automatic t_preempt();
    wr_grp(0);
    expect_win("R4 R5", 8'b0000_0100, 1'b1, 1);   // 0x30 vs 0x50 -> preempt
    expect_win("R9", 8'b0000_0100, 1'b0, 1);
    expect_win("R5 equal", 8'b0100_0000, 1'b1, 1);  // 0x50 vs 0x50
    wr_grp(3);
    expect_win("R4 g3", 8'b0000_0100, 1'b1, 1);
    wr_grp(5);   // group bits [7:6]: 0x30->0, 0x50->1
    expect_win("R1 g5", 8'b0000_0100, 1'b1, 1);
    wr_prio(6, 8'h70);
    expect_win("R1 g5 sub", 8'b0100_0010, 1'b1, 1);  // 0x50 vs 0x70, same group
    wr_grp(4);   // group [7:5]: 0x50->2, 0x70->3
    expect_win("R1 g4", 8'b0000_0010, 1'b1, 6);
    wr_grp(6);
    expect_win("R1 g6", 8'b0000_0100, 1'b1, 0);     // 0x30 vs 0xC0 differ in bit7
    wr_grp(7);
    check("R11 grp", int'(grp_value), 7);
    expect_win("R1 g7", 8'b1000_0001, 1'b1, 0);     // no group field
  endtask

  task automatic t_keep();
    for (int i = 0; i < N; i++) begin
      @(negedge clk); prio_addr = 3'(i); #1;
      check("R6", int'(prio_rdata), int'(model[i]));
    end
  endtask

  initial begin
    for (int i = 0; i < N; i++) model[i] = 8'h00;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_readback();
    t_select();
    t_preempt();
    t_keep();
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #200000;
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule